// File: doc/BRIEF.md
# Byte Hamming Single-Error-Correcting Codec

This block guards one byte with a positional Hamming code. On the encode side a byte is spread over a 12-bit codeword in which four check bits sit at the power-of-two positions, and an optional thirteenth bit carries even parity over the entire word. On the decode side the checks are recomputed from a received word and combined with the stored check bits into a 4-bit syndrome. A nonzero syndrome names the position of the flipped bit, and the decoder inverts that bit.

The decode path returns the repaired byte, a repaired codeword for write-back, and two flags: one for a corrected error and one for an uncorrectable error. With the parity bit present, the block corrects any single error and detects double errors, which it leaves uncorrected. Both paths may end in a register stage with a valid strobe, or stay purely combinational. The choice is made by a parameter.

Top module: `hamming_sec8`

## Requirements
- R1: Codeword bit index i holds position e(i+1). Data bits enc_data_i[0..7] are placed, in ascending order, at positions 3, 5, 6, 7, 9, 10, 11 and 12, which are bit indices 2, 4, 5, 6, 8, 9, 10 and 11.
- R2: The check bits are computed as follows. Position 1 is the XOR of positions 3, 5, 7, 9 and 11. Position 2 is the XOR of positions 3, 6, 7, 10 and 11. Position 4 is the XOR of positions 5, 6, 7 and 12. Position 8 is the XOR of positions 9, 10, 11 and 12.
- R3: With SECDED_EN=1, bit index 12 is set so that all 13 codeword bits have even parity.
- R4: A received word with a zero syndrome and even overall parity returns its data unchanged. Both flags are 0 and dec_code_o equals the input.
- R5: A single flipped data bit is corrected. The flipped bit is found because the syndrome {p8,p4,p2,p1} equals its position. dec_corr_o=1, and the original byte and codeword are returned.
- R6: A single flipped check bit leaves the data unaffected. dec_corr_o=1 and dec_code_o has the check bit restored.
- R7: A flip of the overall parity bit alone gives a zero syndrome with odd parity. It is reported with dec_corr_o=1, and the bit is restored.
- R8: A nonzero syndrome with even overall parity is a double error. The block sets dec_uncorr_o=1 and dec_corr_o=0, applies no correction, and returns the received word and its raw data bits.
- R9: A syndrome of 13, 14 or 15 with odd overall parity sets dec_uncorr_o=1. No correction is applied.
- R10: With OUT_REG=1, each valid output rises one clock after its valid input. The outputs load only on a valid input.
- R11: While rst_ni is low, both valid outputs and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_valid_i | input | 1 | Encode request |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoded word valid |
| enc_code_o | output | CW (13) | Encoded word |
| dec_valid_i | input | 1 | Decode request |
| dec_code_i | input | CW (13) | Received word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 8 | Corrected byte |
| dec_code_o | output | CW (13) | Corrected word for write-back |
| dec_corr_o | output | 1 | A single error was corrected |
| dec_uncorr_o | output | 1 | The error cannot be corrected |

## Verification
Any wrong syndrome bit or wrong data placement shows up at the very next result. It appears either as a codeword that differs from the independently computed encoding, or as a flip of the wrong position, which leaves two bits wrong in dec_code_o. A wrong branch in the error classification swaps the flags, or corrects a word it should leave alone. Every single-bit position and several double and out-of-range patterns are driven for this reason. Each result is compared one cycle after it was issued, so a fault cannot hide behind later traffic.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int BASE_W = DATA_W + CHK_W;

  function automatic logic [BASE_W-1:0] hsec_place(input logic [DATA_W-1:0] d);
    logic [BASE_W-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= BASE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        c[p-1] = d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] hsec_extract(input logic [BASE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= BASE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = c[p-1];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of every position whose index has bit j set; includes the check bit itself
  function automatic logic [CHK_W-1:0] hsec_syndrome(input logic [BASE_W-1:0] c);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int j = 0; j < CHK_W; j++) begin
      for (int p = 1; p <= BASE_W; p++) begin
        if (p[j]) s[j] = s[j] ^ c[p-1];
      end
    end
    return s;
  endfunction

  // returns overall parity in the top bit
  function automatic logic [BASE_W:0] hsec_encode(input logic [DATA_W-1:0] d);
    logic [BASE_W-1:0] c;
    logic [CHK_W-1:0]  s;
    c = hsec_place(d);
    s = hsec_syndrome(c);
    for (int j = 0; j < CHK_W; j++) c[(1 << j) - 1] = s[j];
    return {^c, c};
  endfunction
endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder
  import hsec_pkg::*;
#(
  parameter int unsigned SECDED_EN = 1,
  localparam int CW = BASE_W + SECDED_EN
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW-1:0]     code_o
);
  logic [BASE_W:0] full;

  assign full   = hsec_encode(data_i);
  assign code_o = full[CW-1:0];
endmodule

// File: rtl/hsec_decoder.sv
module hsec_decoder
  import hsec_pkg::*;
#(
  parameter int unsigned SECDED_EN = 1,
  localparam int CW = BASE_W + SECDED_EN
) (
  input  logic [CW-1:0]     code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     code_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  logic [CHK_W-1:0] syn;
  logic             syn_nz;
  logic             in_range;
  logic [CW-1:0]    flip;
  logic [CW-1:0]    pos_mask;

  assign syn      = hsec_syndrome(code_i[BASE_W-1:0]);
  assign syn_nz   = |syn;
  assign in_range = syn <= CHK_W'(BASE_W);

  always_comb begin
    pos_mask = '0;
    for (int p = 1; p <= BASE_W; p++) begin
      if (syn == CHK_W'(p)) pos_mask[p-1] = 1'b1;
    end
  end

  generate
    if (SECDED_EN != 0) begin : g_secded
      logic par_odd;
      assign par_odd = ^code_i;
      always_comb begin
        flip     = '0;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (!syn_nz) begin
          if (par_odd) begin
            flip[CW-1] = 1'b1;
            corr_o     = 1'b1;
          end
        end else if (!par_odd || !in_range) begin
          uncorr_o = 1'b1;
        end else begin
          flip   = pos_mask;
          corr_o = 1'b1;
        end
      end
    end else begin : g_sec
      always_comb begin
        flip     = '0;
        corr_o   = 1'b0;
        uncorr_o = 1'b0;
        if (syn_nz) begin
          if (in_range) begin
            flip   = pos_mask;
            corr_o = 1'b1;
          end else begin
            uncorr_o = 1'b1;
          end
        end
      end
    end
  endgenerate

  assign code_o = code_i ^ flip;
  assign data_o = hsec_extract(code_o[BASE_W-1:0]);
endmodule

// File: rtl/hsec_out_stage.sv
module hsec_out_stage #(
  parameter int unsigned W       = 8,
  parameter int unsigned OUT_REG = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  generate
    if (OUT_REG != 0) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o <= 1'b0;
          data_o  <= '0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) data_o <= data_i;
        end
      end
    end else begin : g_comb
      assign valid_o = valid_i;
      assign data_o  = data_i;
    end
  endgenerate
endmodule

// File: rtl/hamming_sec8.sv
module hamming_sec8
  import hsec_pkg::*;
#(
  parameter int unsigned SECDED_EN = 1,
  parameter int unsigned OUT_REG   = 1,
  localparam int CW    = BASE_W + SECDED_EN,
  localparam int DEC_W = DATA_W + CW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CW-1:0]     enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CW-1:0]     dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [CW-1:0]     dec_code_o,
  output logic              dec_corr_o,
  output logic              dec_uncorr_o
);
  logic [CW-1:0]     enc_code;
  logic [DATA_W-1:0] dec_data;
  logic [CW-1:0]     dec_code;
  logic              dec_corr;
  logic              dec_uncorr;

  hsec_encoder #(.SECDED_EN(SECDED_EN)) u_enc (
    .data_i (enc_data_i),
    .code_o (enc_code)
  );

  hsec_decoder #(.SECDED_EN(SECDED_EN)) u_dec (
    .code_i   (dec_code_i),
    .data_o   (dec_data),
    .code_o   (dec_code),
    .corr_o   (dec_corr),
    .uncorr_o (dec_uncorr)
  );

  hsec_out_stage #(.W(CW), .OUT_REG(OUT_REG)) u_enc_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (enc_valid_i),
    .data_i  (enc_code),
    .valid_o (enc_valid_o),
    .data_o  (enc_code_o)
  );

  hsec_out_stage #(.W(DEC_W), .OUT_REG(OUT_REG)) u_dec_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (dec_valid_i),
    .data_i  ({dec_uncorr, dec_corr, dec_code, dec_data}),
    .valid_o (dec_valid_o),
    .data_o  ({dec_uncorr_o, dec_corr_o, dec_code_o, dec_data_o})
  );

  // assertions
  logic [BASE_W:0] chk_full;
  assign chk_full = hsec_encode(dec_data_o);

  p_flag_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !(dec_corr_o && dec_uncorr_o));

  p_code_consistent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !dec_uncorr_o) |-> (dec_code_o == chk_full[CW-1:0]));

  generate
    if (OUT_REG != 0) begin : g_reg_chk
      p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |=> dec_valid_o);

      p_uncorr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_uncorr_o) |-> (dec_code_o == $past(dec_code_i)));

      p_one_bit_fix_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_valid_o && dec_corr_o) |-> ($countones(dec_code_o ^ $past(dec_code_i)) == 1));
    end
  endgenerate
endmodule

// File: tb/hamming_sec8_tb.sv
module hamming_sec8_tb;
  localparam int CW = 13;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_valid_i = 1'b0;
  logic [7:0]  enc_data_i = '0;
  logic        enc_valid_o;
  logic [CW-1:0] enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [CW-1:0] dec_code_i = '0;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic [CW-1:0] dec_code_o;
  logic        dec_corr_o;
  logic        dec_uncorr_o;

  always #2 clk = ~clk;

  hamming_sec8 u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_code_o(dec_code_o), .dec_corr_o(dec_corr_o),
    .dec_uncorr_o(dec_uncorr_o)
  );

  typedef struct {
    logic [CW-1:0] enc;
    logic [7:0]    data;
    logic [CW-1:0] code;
    logic          corr;
    logic          uncorr;
    string         tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] ref_enc(input logic [7:0] d);
    logic [CW-1:0] c;
    c = '0;
    c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
    c[8] = d[4]; c[9] = d[5]; c[10] = d[6]; c[11] = d[7];
    c[0] = c[2] ^ c[4] ^ c[6] ^ c[8] ^ c[10];
    c[1] = c[2] ^ c[5] ^ c[6] ^ c[9] ^ c[10];
    c[3] = c[4] ^ c[5] ^ c[6] ^ c[11];
    c[7] = c[8] ^ c[9] ^ c[10] ^ c[11];
    c[12] = ^c[11:0];
    return c;
  endfunction

  function automatic logic [7:0] ref_ext(input logic [CW-1:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  // driver: issues one transaction and pushes its expectation
  task automatic send(input logic [7:0] d, input logic [CW-1:0] err, input int kind, input string tag);
    item_t it;
    logic [CW-1:0] good;
    good = ref_enc(d);
    it.enc = good;
    it.tag = tag;
    if (kind == 2) begin
      it.code = good ^ err; it.data = ref_ext(good ^ err); it.corr = 1'b0; it.uncorr = 1'b1;
    end else begin
      it.code = good; it.data = d; it.corr = (kind == 1); it.uncorr = 1'b0;
    end
    @(negedge clk);
    enc_valid_i = 1'b1; enc_data_i = d;
    dec_valid_i = 1'b1; dec_code_i = good ^ err;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    enc_data_i = 8'h00; dec_code_i = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && dec_valid_o) begin
      if (q.size() == 0) begin
        check("R10", "unexpected valid", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        check("R10", "enc_valid", 32'(enc_valid_o), 32'd1);
        check("R1/R2/R3", "enc_code", 32'(enc_code_o), 32'(it.enc));
        check(it.tag, "data", 32'(dec_data_o), 32'(it.data));
        check(it.tag, "code", 32'(dec_code_o), 32'(it.code));
        check(it.tag, "corr", 32'(dec_corr_o), 32'(it.corr));
        check(it.tag, "uncorr", 32'(dec_uncorr_o), 32'(it.uncorr));
      end
    end
  end

  logic [7:0] pats [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};

  initial begin
    repeat (3) @(negedge clk);
    check("R11", "dec_valid_o in reset", 32'(dec_valid_o), 32'd0);
    check("R11", "enc_valid_o in reset", 32'(enc_valid_o), 32'd0);
    check("R11", "flags in reset", 32'({dec_corr_o, dec_uncorr_o}), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      send(pats[i], '0, 0, "R4");
      for (int b = 0; b < CW; b++) begin
        if (b == 12) send(pats[i], 13'(1) << b, 1, "R7");
        else if (b == 0 || b == 1 || b == 3 || b == 7) send(pats[i], 13'(1) << b, 1, "R6");
        else send(pats[i], 13'(1) << b, 1, "R5");
      end
      send(pats[i], 13'h0003, 2, "R8");
      send(pats[i], 13'h0810, 2, "R8");
      send(pats[i], 13'h1004, 2, "R8");
      send(pats[i], 13'h0089, 2, "R9");
      send(pats[i], 13'h008A, 2, "R9");
      send(pats[i], 13'h0803, 2, "R9");
    end
    idle();
    @(negedge clk);
    check("R10", "valid_o drops after idle", 32'(dec_valid_o), 32'd0);
    // hold: outputs keep last result while idle
    check("R10", "outputs hold while idle", 32'(dec_code_o), 32'(ref_enc(8'hC3) ^ 13'h0803));
    send(8'h96, '0, 0, "R4");
    idle();
    repeat (3) @(negedge clk);
    check("R10", "queue drained", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule